// File: doc/BRIEF.md
# Sector ID Search and Read Sequencer

This block runs the search part of a multi-sector read. A command gives a wanted track, head, starting sector, size code, the last sector number of the run and a skip flag for deleted sectors. The block then watches decoded address-field events from the data separator and compares each one with the sector it currently wants. When an address field matches, it waits for the data field of that sector. A normal data field, or a deleted one while skipping is off, produces a one-cycle read strobe together with the sector number. The wanted sector then steps by one until the last sector of the run has been read.

The search for one sector ends in failure when two index pulses arrive before a match. It also ends when an address field has a bad CRC, or when the data field of a matched sector times out. A host abort ends the operation at once. The result phase is shown by a held done flag and a six-bit result field, which describes why the run stopped. Sector data transfer, CRC computation, seeking and the data separator all sit outside this block.

States: IDLE (after reset), SEARCH (looking at address fields and counting index pulses), WAIT_DATA (matched ID, waiting for the data field), DELIVER (one cycle with the read strobe high), RESULT (done held). Transitions: IDLE/RESULT to SEARCH on start. SEARCH to WAIT_DATA on a matching ID. SEARCH to RESULT on abort, on a bad CRC or on the second index pulse. SEARCH stays in SEARCH on a mismatch. WAIT_DATA to DELIVER on a data field that is read. WAIT_DATA to SEARCH or RESULT on a skipped deleted field. WAIT_DATA to RESULT on timeout or abort. DELIVER to SEARCH for the next sector, or to RESULT after the last one.

Top module: `rdsec_seq`

## Requirements
- R1: After reset the block is idle: done=0, busy=0, read_go=0 and res_flags=0. res_flags stays 0 whenever done is 0.
- R2: In SEARCH each address field with good CRC is compared with the wanted track, head, current sector and size code. A mismatch keeps the block in SEARCH. A full match moves it to wait for a data field, with busy=1 and done=0.
- R3: When the second index pulse of a sector search arrives without a match, the block enters RESULT. If no good address field was seen in that search, bit 0 (no mark) is set.
- R4: On that index termination, bit 4 (wrong track) is set if an address field seen in the search had a differing track. If that differing track was all ones, bit 5 (bad track) is set instead. Bit 1 (not found) is set if any seen field differed in head, sector or size.
- R5: An address field with a bad CRC in SEARCH ends the operation with bit 2 (CRC error) set.
- R6: A data-field timeout after a match ends the operation with bit 3 (missing data) set.
- R7: A deleted data field while skip is set produces no read strobe and advances to the next sector. With skip clear, a deleted field is read like a normal one.
- R8: A data field that is read gives read_go high for exactly one cycle, one cycle after the data event, with cur_sec equal to that sector. The sector then steps by one. After the sector equal to the end-of-track number, the block enters RESULT with res_flags=0.
- R9: A host abort in SEARCH or WAIT_DATA enters RESULT with res_flags=0.
- R10: The index pulse count and the record of seen address fields restart at each new sector search, so one index pulse before and one after a sector change do not end the run.
- R11: done holds until the next start. A start while busy is ignored, and a start from RESULT clears res_flags and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run with the command fields (accepted when idle or done) |
| cmd_trk | input | 8 | Wanted track |
| cmd_head | input | 8 | Wanted head |
| cmd_sec | input | 8 | First sector of the run |
| cmd_size | input | 8 | Wanted size code |
| cmd_eot | input | 8 | Last sector number of the run |
| cmd_skip | input | 1 | Skip sectors with a deleted data mark |
| af_valid | input | 1 | Address field decoded this cycle |
| af_trk | input | 8 | Track byte of the address field |
| af_head | input | 8 | Head byte of the address field |
| af_sec | input | 8 | Sector byte of the address field |
| af_size | input | 8 | Size code byte of the address field |
| af_crc_ok | input | 1 | Address field CRC was good |
| df_valid | input | 1 | Data field mark found this cycle |
| df_deleted | input | 1 | The data field mark is the deleted kind |
| index_pulse | input | 1 | One-cycle index pulse |
| df_timeout | input | 1 | Data field did not arrive in time |
| host_abort | input | 1 | Host abort strobe |
| read_go | output | 1 | One-cycle strobe: read the data of cur_sec |
| cur_sec | output | 8 | Sector currently wanted or being read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result phase |
| res_flags | output | 6 | Result: bit0 no mark, bit1 not found, bit2 CRC error, bit3 missing data, bit4 wrong track, bit5 bad track |

## Verification
Directed runs cover each way a search can end: no address field at all, a track byte of all ones against an ordinary wrong track, head-only and sector-only mismatches, a bad CRC, a data timeout and aborts in both busy states. Each of these leaves its own result code. Multi-sector runs with and without skip, fed deleted marks, show whether a deleted sector produces a strobe or only moves the sector on. A run with one index pulse on each side of a sector change tells a per-sector count apart from a count kept over the whole run. A long random stream then mixes matching and perturbed IDs, index pulses, timeouts, aborts and restarts, and a bench model compares every cycle.

// File: rtl/rdsec_pkg.sv
package rdsec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_WAIT_DATA,
        ST_DELIVER,
        ST_RESULT
    } seq_state_t;

    localparam int FLAG_W     = 6;
    localparam int F_NOMARK   = 0;
    localparam int F_NOTFOUND = 1;
    localparam int F_CRC      = 2;
    localparam int F_NODATA   = 3;
    localparam int F_WRONGTRK = 4;
    localparam int F_BADTRK   = 5;

endpackage

// File: rtl/rdsec_idcmp.sv
module rdsec_idcmp #(
    parameter int ID_W = 8,
    parameter int SZ_W = 8
) (
    input  logic [ID_W-1:0] want_trk,
    input  logic [ID_W-1:0] want_head,
    input  logic [ID_W-1:0] want_sec,
    input  logic [SZ_W-1:0] want_size,
    input  logic [ID_W-1:0] got_trk,
    input  logic [ID_W-1:0] got_head,
    input  logic [ID_W-1:0] got_sec,
    input  logic [SZ_W-1:0] got_size,
    output logic            id_match,
    output logic            trk_diff,
    output logic            trk_all_ones,
    output logic            rest_diff
);
    localparam logic [ID_W-1:0] TRK_ONES = '1;

    logic head_diff;
    logic sec_diff;
    logic size_diff;

    always_comb begin
        trk_diff     = (want_trk != got_trk);
        head_diff    = (want_head != got_head);
        sec_diff     = (want_sec != got_sec);
        size_diff    = (want_size != got_size);
        trk_all_ones = (got_trk == TRK_ONES);
        rest_diff    = head_diff | sec_diff | size_diff;
        id_match     = !trk_diff && !rest_diff;
    end

endmodule

// File: rtl/rdsec_idxwatch.sv
module rdsec_idxwatch #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        expire = tick && (cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && !expire) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R10: a cleared search starts counting from zero
    assert_idx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R3: the count never passes the termination point
    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LIMIT));

endmodule

// File: rtl/rdsec_misslog.sv
module rdsec_misslog
    import rdsec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              note,
    input  logic              trk_diff,
    input  logic              trk_all_ones,
    input  logic              rest_diff,
    output logic [FLAG_W-1:0] term_flags
);
    logic seen_q;
    logic trk_q;
    logic ones_q;
    logic rest_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            trk_q  <= 1'b0;
            ones_q <= 1'b0;
            rest_q <= 1'b0;
        end else if (clr) begin
            seen_q <= 1'b0;
            trk_q  <= 1'b0;
            ones_q <= 1'b0;
            rest_q <= 1'b0;
        end else if (note) begin
            seen_q <= 1'b1;
            if (trk_diff) begin
                trk_q  <= 1'b1;
                ones_q <= trk_all_ones;
            end
            if (rest_diff) begin
                rest_q <= 1'b1;
            end
        end
    end

    always_comb begin
        term_flags             = '0;
        term_flags[F_NOMARK]   = !seen_q;
        term_flags[F_NOTFOUND] = rest_q;
        term_flags[F_WRONGTRK] = trk_q && !ones_q;
        term_flags[F_BADTRK]   = trk_q && ones_q;
    end

    // R4: wrong-track and bad-track codes never appear together
    assert_trk_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(term_flags[F_WRONGTRK] && term_flags[F_BADTRK]));

    // R10: the log is empty after a clear
    assert_log_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (term_flags == FLAG_W'(1 << F_NOMARK)));

endmodule

// File: rtl/rdsec_seq.sv
module rdsec_seq
    import rdsec_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int SZ_W      = 8,
    parameter int IDX_LIMIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   cmd_trk,
    input  logic [ID_W-1:0]   cmd_head,
    input  logic [ID_W-1:0]   cmd_sec,
    input  logic [SZ_W-1:0]   cmd_size,
    input  logic [ID_W-1:0]   cmd_eot,
    input  logic              cmd_skip,
    input  logic              af_valid,
    input  logic [ID_W-1:0]   af_trk,
    input  logic [ID_W-1:0]   af_head,
    input  logic [ID_W-1:0]   af_sec,
    input  logic [SZ_W-1:0]   af_size,
    input  logic              af_crc_ok,
    input  logic              df_valid,
    input  logic              df_deleted,
    input  logic              index_pulse,
    input  logic              df_timeout,
    input  logic              host_abort,
    output logic              read_go,
    output logic [ID_W-1:0]   cur_sec,
    output logic              busy,
    output logic              done,
    output logic [FLAG_W-1:0] res_flags
);
    seq_state_t st;
    seq_state_t nxt;

    logic [ID_W-1:0]   trk_q;
    logic [ID_W-1:0]   head_q;
    logic [SZ_W-1:0]   size_q;
    logic [ID_W-1:0]   eot_q;
    logic              skip_q;

    logic              id_match;
    logic              id_trk_diff;
    logic              id_trk_ones;
    logic              id_rest_diff;
    logic              idx_expire;
    logic [FLAG_W-1:0] log_flags;

    logic              take_cmd;
    logic              advance;
    logic              last_sec;
    logic              finish;
    logic [FLAG_W-1:0] end_flags;
    logic              search_clr;
    logic              in_search;
    logic              note_miss;
    logic              idx_tick;

    rdsec_idcmp #(.ID_W(ID_W), .SZ_W(SZ_W)) u_cmp (
        .want_trk     (trk_q),
        .want_head    (head_q),
        .want_sec     (cur_sec),
        .want_size    (size_q),
        .got_trk      (af_trk),
        .got_head     (af_head),
        .got_sec      (af_sec),
        .got_size     (af_size),
        .id_match     (id_match),
        .trk_diff     (id_trk_diff),
        .trk_all_ones (id_trk_ones),
        .rest_diff    (id_rest_diff)
    );

    rdsec_idxwatch #(.LIMIT(IDX_LIMIT)) u_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (search_clr),
        .tick   (idx_tick),
        .expire (idx_expire)
    );

    rdsec_misslog u_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (search_clr),
        .note         (note_miss),
        .trk_diff     (id_trk_diff),
        .trk_all_ones (id_trk_ones),
        .rest_diff    (id_rest_diff),
        .term_flags   (log_flags)
    );

    // Event qualification for the search-side helpers
    always_comb begin
        in_search  = (st == ST_SEARCH) && !host_abort;
        note_miss  = in_search && af_valid && af_crc_ok && !id_match;
        idx_tick   = in_search && !af_valid && index_pulse;
        last_sec   = (cur_sec == eot_q);
        take_cmd   = start && ((st == ST_IDLE) || (st == ST_RESULT));
        search_clr = take_cmd || (advance && !last_sec);
    end

    // Next-state decision
    always_comb begin
        nxt       = st;
        advance   = 1'b0;
        finish    = 1'b0;
        end_flags = '0;
        unique case (st)
            ST_IDLE, ST_RESULT: begin
                if (start) begin
                    nxt = ST_SEARCH;
                end
            end
            ST_SEARCH: begin
                if (host_abort) begin
                    finish = 1'b1;
                end else if (af_valid) begin
                    if (!af_crc_ok) begin
                        finish           = 1'b1;
                        end_flags[F_CRC] = 1'b1;
                    end else if (id_match) begin
                        nxt = ST_WAIT_DATA;
                    end
                end else if (idx_expire) begin
                    finish    = 1'b1;
                    end_flags = log_flags;
                end
            end
            ST_WAIT_DATA: begin
                if (host_abort) begin
                    finish = 1'b1;
                end else if (df_valid) begin
                    if (df_deleted && skip_q) begin
                        advance = 1'b1;
                    end else begin
                        nxt = ST_DELIVER;
                    end
                end else if (df_timeout) begin
                    finish              = 1'b1;
                    end_flags[F_NODATA] = 1'b1;
                end
            end
            ST_DELIVER: begin
                advance = 1'b1;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
        if (advance) begin
            if (last_sec) begin
                finish = 1'b1;
            end else begin
                nxt = ST_SEARCH;
            end
        end
        if (finish) begin
            nxt = ST_RESULT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Command, sector and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q     <= '0;
            head_q    <= '0;
            size_q    <= '0;
            eot_q     <= '0;
            skip_q    <= 1'b0;
            cur_sec   <= '0;
            res_flags <= '0;
        end else if (take_cmd) begin
            trk_q     <= cmd_trk;
            head_q    <= cmd_head;
            size_q    <= cmd_size;
            eot_q     <= cmd_eot;
            skip_q    <= cmd_skip;
            cur_sec   <= cmd_sec;
            res_flags <= '0;
        end else begin
            if (advance && !last_sec) begin
                cur_sec <= cur_sec + ID_W'(1);
            end
            if (finish) begin
                res_flags <= end_flags;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        read_go = (st == ST_DELIVER);
        done    = (st == ST_RESULT);
        busy    = (st == ST_SEARCH) || (st == ST_WAIT_DATA) || (st == ST_DELIVER);
    end

    // R8: the read strobe lasts one cycle
    assert_go_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        read_go |=> !read_go);

    // R11: the result phase holds until a new start
    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R1: no result code outside the result phase
    assert_flags_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (res_flags == '0));

    // R5: a CRC code only follows a bad address field
    assert_crc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_flags[F_CRC]) |-> $past(af_valid && !af_crc_ok));

    // R6: a missing-data code only follows a timeout while waiting
    assert_md_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_flags[F_NODATA]) |-> $past((st == ST_WAIT_DATA) && df_timeout));

endmodule

// File: tb/rdsec_seq_test.sv
module rdsec_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cmd_trk = '0, cmd_head = '0, cmd_sec = '0, cmd_size = '0, cmd_eot = '0;
    logic       cmd_skip = 1'b0;
    logic       af_valid = 1'b0;
    logic [7:0] af_trk = '0, af_head = '0, af_sec = '0, af_size = '0;
    logic       af_crc_ok = 1'b0;
    logic       df_valid = 1'b0, df_deleted = 1'b0;
    logic       index_pulse = 1'b0, df_timeout = 1'b0, host_abort = 1'b0;
    logic       read_go, busy, done;
    logic [7:0] cur_sec;
    logic [5:0] res_flags;

    int checks = 0;
    int errors = 0;
    int go_seen = 0;

    // bench model
    int         m_st;      // 0 idle 1 search 2 wait 3 deliver 4 result
    logic [7:0] m_sec, m_eot, m_trk, m_head, m_size;
    logic       m_skip;
    int         m_cnt;
    logic       m_seen, m_td, m_ff, m_rd;
    logic [5:0] m_flags;
    string      m_tag;

    localparam int EV_IDLE = 0, EV_START = 1, EV_AF = 2, EV_DF = 3, EV_IDX = 4, EV_TMO = 5, EV_ABORT = 6;

    always #5 clk = ~clk;

    rdsec_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_trk(cmd_trk), .cmd_head(cmd_head), .cmd_sec(cmd_sec), .cmd_size(cmd_size),
        .cmd_eot(cmd_eot), .cmd_skip(cmd_skip),
        .af_valid(af_valid), .af_trk(af_trk), .af_head(af_head), .af_sec(af_sec),
        .af_size(af_size), .af_crc_ok(af_crc_ok),
        .df_valid(df_valid), .df_deleted(df_deleted), .index_pulse(index_pulse),
        .df_timeout(df_timeout), .host_abort(host_abort),
        .read_go(read_go), .cur_sec(cur_sec), .busy(busy), .done(done), .res_flags(res_flags)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] index_end_flags(input logic seen, input logic td,
                                                   input logic ff, input logic rd);
        logic [5:0] f;
        f = '0;
        f[0] = !seen;
        f[1] = rd;
        f[4] = td && !ff;
        f[5] = td && ff;
        return f;
    endfunction

    task automatic m_clear_search();
        m_cnt = 0; m_seen = 0; m_td = 0; m_ff = 0; m_rd = 0;
    endtask

    task automatic m_advance();
        if (m_sec == m_eot) begin
            m_st = 4; m_flags = '0; m_tag = "R8";
        end else begin
            m_sec = m_sec + 8'd1; m_st = 1; m_clear_search();
        end
    endtask

    // one cycle of stimulus, then model update and output comparison
    task automatic step(input int ev, input logic [7:0] t, input logic [7:0] h,
                        input logic [7:0] s, input logic [7:0] z, input logic crcok,
                        input logic del);
        logic [31:0] act, exp;
        case (ev)
            EV_START: start = 1'b1;
            EV_AF: begin
                af_valid = 1'b1; af_trk = t; af_head = h; af_sec = s; af_size = z; af_crc_ok = crcok;
            end
            EV_DF: begin df_valid = 1'b1; df_deleted = del; end
            EV_IDX: index_pulse = 1'b1;
            EV_TMO: df_timeout = 1'b1;
            EV_ABORT: host_abort = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        start = 0; af_valid = 0; af_crc_ok = 0; df_valid = 0; df_deleted = 0;
        index_pulse = 0; df_timeout = 0; host_abort = 0;
        case (m_st)
            0, 4: if (ev == EV_START) begin
                m_trk = cmd_trk; m_head = cmd_head; m_sec = cmd_sec; m_size = cmd_size;
                m_eot = cmd_eot; m_skip = cmd_skip; m_flags = '0; m_st = 1;
                m_clear_search(); m_tag = "R11";
            end
            1: begin
                if (ev == EV_ABORT) begin
                    m_st = 4; m_flags = '0; m_tag = "R9";
                end else if (ev == EV_AF) begin
                    if (!crcok) begin
                        m_st = 4; m_flags = 6'b000100; m_tag = "R5";
                    end else if (t == m_trk && h == m_head && s == m_sec && z == m_size) begin
                        m_st = 2; m_tag = "R2";
                    end else begin
                        m_seen = 1; m_tag = "R2";
                        if (t != m_trk) begin m_td = 1; m_ff = (t == 8'hFF); end
                        if (h != m_head || s != m_sec || z != m_size) m_rd = 1;
                    end
                end else if (ev == EV_IDX) begin
                    m_cnt++;
                    m_tag = "R10";
                    if (m_cnt == 2) begin
                        m_st = 4; m_flags = index_end_flags(m_seen, m_td, m_ff, m_rd);
                        m_tag = m_seen ? "R4" : "R3";
                    end
                end else if (ev == EV_START) m_tag = "R11";
            end
            2: begin
                if (ev == EV_ABORT) begin
                    m_st = 4; m_flags = '0; m_tag = "R9";
                end else if (ev == EV_DF) begin
                    if (del && m_skip) begin m_tag = "R7"; m_advance(); end
                    else begin m_st = 3; m_tag = del ? "R7" : "R8"; end
                end else if (ev == EV_TMO) begin
                    m_st = 4; m_flags = 6'b001000; m_tag = "R6";
                end
            end
            3: m_advance();
            default: ;
        endcase
        if (read_go) go_seen++;
        act = {read_go, done, busy, res_flags, (read_go ? cur_sec : 8'h00)};
        exp = {(m_st == 3), (m_st == 4), (m_st >= 1 && m_st <= 3), m_flags,
               ((m_st == 3) ? m_sec : 8'h00)};
        chk(act == exp, m_tag, act, exp);
    endtask

    task automatic idle();
        step(EV_IDLE, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic begin_run(input logic [7:0] t, input logic [7:0] h, input logic [7:0] s,
                             input logic [7:0] z, input logic [7:0] e, input logic sk);
        cmd_trk = t; cmd_head = h; cmd_sec = s; cmd_size = z; cmd_eot = e; cmd_skip = sk;
        step(EV_START, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic good_af(input logic [7:0] s);
        step(EV_AF, m_trk, m_head, s, m_size, 1, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        m_st = 0; m_flags = '0; m_tag = "R1"; m_sec = 0; m_eot = 0;
        m_trk = 0; m_head = 0; m_size = 0; m_skip = 0; m_clear_search();
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!done && !busy && !read_go && res_flags == 0, "R1", {done, busy, read_go, res_flags}, 0);
        idle();

        // R3 no address field at all
        begin_run(8'd5, 8'd0, 8'd1, 8'd2, 8'd1, 0);
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        chk(busy && !done, "R3", {busy, done}, 2'b10);
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        chk(res_flags == 6'b000001, "R3", res_flags, 6'b000001);

        // R4 bad track (all ones)
        begin_run(8'd5, 8'd0, 8'd1, 8'd2, 8'd1, 0);
        step(EV_AF, 8'hFF, 8'd0, 8'd1, 8'd2, 1, 0);
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        chk(res_flags == 6'b100000, "R4", res_flags, 6'b100000);

        // R4 ordinary wrong track
        begin_run(8'd5, 8'd0, 8'd1, 8'd2, 8'd1, 0);
        step(EV_AF, 8'd6, 8'd0, 8'd1, 8'd2, 1, 0);
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        chk(res_flags == 6'b010000, "R4", res_flags, 6'b010000);

        // R4 head-only mismatch
        begin_run(8'd5, 8'd0, 8'd1, 8'd2, 8'd1, 0);
        step(EV_AF, 8'd5, 8'd1, 8'd1, 8'd2, 1, 0);
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        chk(res_flags == 6'b000010, "R4", res_flags, 6'b000010);

        // R5 bad CRC
        begin_run(8'd5, 8'd0, 8'd1, 8'd2, 8'd1, 0);
        step(EV_AF, 8'd5, 8'd0, 8'd1, 8'd2, 0, 0);
        chk(done && res_flags == 6'b000100, "R5", res_flags, 6'b000100);

        // R2 mismatch then match, R6 timeout
        begin_run(8'd7, 8'd1, 8'd3, 8'd2, 8'd3, 0);
        step(EV_AF, 8'd7, 8'd1, 8'd4, 8'd2, 1, 0);
        chk(busy && !done, "R2", {busy, done}, 2'b10);
        good_af(8'd3);
        step(EV_TMO, 0, 0, 0, 0, 0, 0);
        chk(res_flags == 6'b001000, "R6", res_flags, 6'b001000);

        // R8 three sectors to the end of track
        go_seen = 0;
        begin_run(8'd2, 8'd0, 8'd1, 8'd2, 8'd3, 0);
        for (int s = 1; s <= 3; s++) begin
            good_af(8'(s));
            step(EV_DF, 0, 0, 0, 0, 0, 0);
            idle();
        end
        chk(done && res_flags == 0 && go_seen == 3, "R8", go_seen, 3);

        // R7 skip a deleted sector, then read the next
        go_seen = 0;
        begin_run(8'd2, 8'd0, 8'd1, 8'd2, 8'd2, 1);
        good_af(8'd1);
        step(EV_DF, 0, 0, 0, 0, 0, 1);
        chk(!read_go && busy, "R7", {read_go, busy}, 2'b01);
        good_af(8'd2);
        step(EV_DF, 0, 0, 0, 0, 0, 0);
        chk(read_go && cur_sec == 8'd2, "R7", cur_sec, 8'd2);
        idle();
        chk(done && go_seen == 1, "R7", go_seen, 1);

        // R7 deleted read when skip is clear
        begin_run(8'd2, 8'd0, 8'd4, 8'd2, 8'd4, 0);
        good_af(8'd4);
        step(EV_DF, 0, 0, 0, 0, 0, 1);
        chk(read_go && cur_sec == 8'd4, "R7", cur_sec, 8'd4);
        idle();

        // R9 aborts in search and in wait
        begin_run(8'd2, 8'd0, 8'd1, 8'd2, 8'd1, 0);
        step(EV_ABORT, 0, 0, 0, 0, 0, 0);
        chk(done && res_flags == 0, "R9", res_flags, 0);
        begin_run(8'd2, 8'd0, 8'd1, 8'd2, 8'd1, 0);
        good_af(8'd1);
        step(EV_ABORT, 0, 0, 0, 0, 0, 0);
        chk(done && res_flags == 0, "R9", res_flags, 0);

        // R10 one index on each side of a sector change
        begin_run(8'd2, 8'd0, 8'd1, 8'd2, 8'd2, 0);
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        good_af(8'd1);
        step(EV_DF, 0, 0, 0, 0, 0, 0);
        idle();
        step(EV_IDX, 0, 0, 0, 0, 0, 0);
        chk(busy && !done, "R10", {busy, done}, 2'b10);
        good_af(8'd2);
        step(EV_DF, 0, 0, 0, 0, 0, 0);
        idle();
        chk(done && res_flags == 0, "R10", res_flags, 0);

        // R11 done holds; start while busy ignored
        idle(); idle();
        chk(done, "R11", done, 1);
        begin_run(8'd3, 8'd0, 8'd1, 8'd2, 8'd1, 0);
        begin_run(8'd9, 8'd0, 8'd1, 8'd2, 8'd1, 0);
        step(EV_AF, 8'd3, 8'd0, 8'd1, 8'd2, 1, 0);
        chk(busy && !done && !read_go, "R11", {busy, done}, 2'b10);
        step(EV_DF, 0, 0, 0, 0, 0, 0);
        idle();

        // random mix
        for (int n = 0; n < 6000; n++) begin
            int unsigned u;
            u = $urandom % 100;
            if (m_st == 0 || m_st == 4) begin
                logic [7:0] s0;
                s0 = 8'(1 + $urandom % 4);
                begin_run(8'($urandom % 80), 8'($urandom % 2), s0, 8'($urandom % 4),
                          s0 + 8'($urandom % 3), 1'($urandom % 2));
            end else if (m_st == 1) begin
                if (u < 60) begin
                    int unsigned k;
                    logic [7:0] t, h, s, z;
                    k = $urandom % 10;
                    t = m_trk; h = m_head; s = m_sec; z = m_size;
                    if (k == 5) t = ($urandom % 2) ? 8'hFF : m_trk + 8'd1;
                    if (k == 6) s = m_sec + 8'd1;
                    if (k == 7) h = m_head ^ 8'd1;
                    if (k == 8) z = m_size + 8'd1;
                    step(EV_AF, t, h, s, z, !(k == 9 && ($urandom % 2)), 0);
                end else if (u < 78) step(EV_IDX, 0, 0, 0, 0, 0, 0);
                else if (u < 80) step(EV_ABORT, 0, 0, 0, 0, 0, 0);
                else if (u < 82) step(EV_START, 0, 0, 0, 0, 0, 0);
                else idle();
            end else if (m_st == 2) begin
                if (u < 70) step(EV_DF, 0, 0, 0, 0, 0, 1'($urandom % 3 == 0));
                else if (u < 78) step(EV_TMO, 0, 0, 0, 0, 0, 0);
                else if (u < 81) step(EV_ABORT, 0, 0, 0, 0, 0, 0);
                else idle();
            end else begin
                idle();
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule